// File: doc/BRIEF.md
# Parallel Offset Register Access Port

This block holds the two threshold offsets of a FIFO: one for the almost-empty flag and one for the almost-full flag. It lets them be loaded and read back over the FIFO's own data buses. The buses carry 36, 18 or 9 useful bits, chosen by a strap. With a narrow bus, each offset is moved as an ordered series of segments. The low segment goes first.

The write and read paths each have their own segment pointer. Each pointer is a six-state machine with the states `SEG_E0`, `SEG_E1`, `SEG_E2`, `SEG_F0`, `SEG_F1` and `SEG_F2` (E for the empty offset, F for the full offset, and the digit is the segment number).

The transitions depend on the strap:
- **36-bit bus:** `SEG_E0 -> SEG_F0 -> SEG_E0`.
- **18-bit bus:** `SEG_E0 -> SEG_E1 -> SEG_F0 -> SEG_F1 -> SEG_E0`.
- **9-bit bus:** `SEG_E0 -> SEG_E1 -> SEG_E2 -> SEG_F0 -> SEG_F1 -> SEG_F2 -> SEG_E0`.

A pointer moves only on a qualified access. In every other cycle it holds its state, so offset accesses can be mixed freely with ordinary FIFO traffic.

Read-back goes through the same output register that ordinary FIFO reads use. A partial reset clears that register but leaves both pointers alone. Two validity outputs tell the flag logic whether each offset is complete. Each validity level passes through two flip-flops of the clock domain that uses it.

Top module: `ofs_access_port`

## Requirements
- R1: While `mrst_n` is low, both pointers return to `SEG_E0`, the empty and full offsets take their parameter defaults, `q` is zero, and both validity outputs are 1.
- R2: With `bus_cfg` = 0 (36-bit), each offset write or read alternates between the empty and the full offset, starting with empty. Code 3 behaves the same way.
- R3: With `bus_cfg` = 1 (18-bit), the order is empty low, empty high, full low, full high, then back to empty low.
- R4: With `bus_cfg` = 2 (9-bit), the order has six steps: empty segments 0, 1 and 2, then full segments 0, 1 and 2. Offset bits at position `OFS_W` and above are dropped.
- R5: An offset write to segment k of width W copies `din[W-1:0]` into bits `[k*W +: W]` of the selected offset. All other bits of both offsets are kept.
- R6: At a `rclk` edge with `ld_n` = 0, `ren_n` = 0 and `prst_n` = 1, `q` is replaced by the read pointer's segment, placed at bit 0 and zero-extended. The read pointer then advances.
- R7: When `ld_n` = 1, a write with `wen_n` = 0 changes neither offset nor the write pointer. When `wen_n` = 1 (or, on the read side, `ren_n` = 1), the pointer holds its position. The sequence resumes from where it stopped.
- R8: At a `rclk` edge with `ld_n` = 1 and `ren_n` = 0, `q` takes `fifo_word`. In a cycle with no read and `prst_n` = 1, `q` holds its value.
- R9: At a `rclk` edge with `prst_n` = 0, `q` is cleared. The read pointer and both offsets are unchanged.
- R10: A write to `SEG_E0` clears the validity of both flags. A write to any other empty segment that is not the last one clears the empty validity. A write to a full segment that is not the last one clears the full validity.
- R11: A write to the last empty segment sets the empty validity. A write to the last full segment sets the full validity. `pae_ok` follows the empty validity two `rclk` edges later, and `paf_ok` follows the full validity two `wclk` edges later.
- R12: When an offset write and an offset read share one edge of a common clock, the read returns the offset including that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous to `rclk`, active low |
| bus_cfg | input | 2 | Bus width strap: 0 = 36-bit, 1 = 18-bit, 2 = 9-bit, 3 = 36-bit |
| ld_n | input | 1 | Offset access select, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | 36 | Write data bus |
| fifo_word | input | 36 | Word supplied by FIFO storage for ordinary reads |
| q | output | 36 | Registered output bus |
| pae_ok | output | 1 | Empty offset complete, in the `rclk` domain |
| paf_ok | output | 1 | Full offset complete, in the `wclk` domain |

## Verification
The assertions assume four things about the inputs:
- `bus_cfg` changes only while `mrst_n` is low.
- `mrst_n` is released away from clock edges and held low across at least two edges.
- A read and a write to the offsets in the same cycle happen only when `wclk` and `rclk` are the same clock.
- The checks that compare an output with the value two edges earlier hold only after reset has been released for two cycles.

The stimulus respects all four. It drives one clock into both clock pins and changes the strap only inside master-reset pulses. It holds reset for three cycles and drives every input half a cycle away from the active edge.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        BUS_X36 = 2'd0,
        BUS_X18 = 2'd1,
        BUS_X9  = 2'd2,
        BUS_RSV = 2'd3
    } bus_cfg_e;

    typedef enum logic [2:0] {
        SEG_E0 = 3'd0,
        SEG_E1 = 3'd1,
        SEG_E2 = 3'd2,
        SEG_F0 = 3'd3,
        SEG_F1 = 3'd4,
        SEG_F2 = 3'd5
    } seg_e;

    localparam int BUS_W = 36;

    // segments per offset for a strap value
    function automatic int seg_count(input logic [1:0] cfg);
        case (cfg)
            BUS_X18: return 2;
            BUS_X9:  return 3;
            default: return 1;
        endcase
    endfunction

    // useful bus bits for a strap value
    function automatic int seg_width(input logic [1:0] cfg);
        case (cfg)
            BUS_X18: return 18;
            BUS_X9:  return 9;
            default: return 36;
        endcase
    endfunction

    function automatic int seg_index(input seg_e s);
        case (s)
            SEG_E1, SEG_F1: return 1;
            SEG_E2, SEG_F2: return 2;
            default:        return 0;
        endcase
    endfunction

    function automatic logic is_full(input seg_e s);
        return (s == SEG_F0) || (s == SEG_F1) || (s == SEG_F2);
    endfunction

endpackage

// File: rtl/ofs_seq.sv
module ofs_seq
    import ofs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg,
    input  logic       step,
    output seg_e       seg
);

    seg_e state_q;
    seg_e state_d;
    logic multi;
    logic triple;

    assign multi  = (cfg == BUS_X18) || (cfg == BUS_X9);
    assign triple = (cfg == BUS_X9);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEG_E0;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SEG_E0:  state_d = multi  ? SEG_E1 : SEG_F0;
                SEG_E1:  state_d = triple ? SEG_E2 : SEG_F0;
                SEG_E2:  state_d = SEG_F0;
                SEG_F0:  state_d = multi  ? SEG_F1 : SEG_E0;
                SEG_F1:  state_d = triple ? SEG_F2 : SEG_E0;
                SEG_F2:  state_d = SEG_E0;
                default: state_d = SEG_E0;
            endcase
        end
    end

    // outputs
    assign seg = state_q;

    // R2
    x36_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg == BUS_X36) || (cfg == BUS_RSV)) |-> ((state_q == SEG_E0) || (state_q == SEG_F0)));

    // R3
    x18_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == BUS_X18) |-> ((state_q != SEG_E2) && (state_q != SEG_F2)));

    // R7
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import ofs_pkg::*;
#(
    parameter int               OFS_W     = 20,
    parameter logic [OFS_W-1:0] DEF_EMPTY = 'd7,
    parameter logic [OFS_W-1:0] DEF_FULL  = 'd100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg,
    input  logic             wr,
    input  seg_e             wseg,
    input  logic [35:0]      din,
    output logic [OFS_W-1:0] e_nxt,
    output logic [OFS_W-1:0] f_nxt,
    output logic             e_good,
    output logic             f_good
);

    localparam int PAD_W = 64 - BUS_W;

    logic [OFS_W-1:0] e_q;
    logic [OFS_W-1:0] f_q;
    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] dat;
    logic [35:0]      smask;
    logic [63:0]      wm;
    logic [63:0]      wd;
    logic             last_seg;
    int               segw;
    int               lo;

    always_comb begin
        segw  = seg_width(cfg);
        lo    = seg_index(wseg) * segw;
        smask = (36'd1 << segw) - 36'd1;
        wm    = {{PAD_W{1'b0}}, smask} << lo;
        wd    = {{PAD_W{1'b0}}, din & smask} << lo;
        mask  = wm[OFS_W-1:0];
        dat   = wd[OFS_W-1:0];
        e_nxt = e_q;
        f_nxt = f_q;
        if (wr) begin
            if (is_full(wseg)) begin
                f_nxt = (f_q & ~mask) | (dat & mask);
            end else begin
                e_nxt = (e_q & ~mask) | (dat & mask);
            end
        end
    end

    assign last_seg = (seg_index(wseg) == seg_count(cfg) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= DEF_EMPTY;
            f_q    <= DEF_FULL;
            e_good <= 1'b1;
            f_good <= 1'b1;
        end else begin
            e_q <= e_nxt;
            f_q <= f_nxt;
            if (wr) begin
                if (is_full(wseg)) begin
                    f_good <= last_seg;
                end else begin
                    if (wseg == SEG_E0) begin
                        f_good <= 1'b0;
                    end
                    e_good <= last_seg;
                end
            end
        end
    end

    // R7
    reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(e_q) && $stable(f_q)));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wseg == SEG_E0) && (cfg != BUS_X36) && (cfg != BUS_RSV)) |=> (!e_good && !f_good));

endmodule

// File: rtl/ofs_flag_sync.sv
module ofs_flag_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic ok
);

    logic s1_q;
    logic s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= lvl;
            s2_q <= s1_q;
        end
    end

    assign ok = s2_q;

    // R11
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (ok == $past(lvl, 2)));

endmodule

// File: rtl/ofs_access_port.sv
module ofs_access_port
    import ofs_pkg::*;
#(
    parameter int               OFS_W     = 20,
    parameter logic [OFS_W-1:0] DEF_EMPTY = 'd7,
    parameter logic [OFS_W-1:0] DEF_FULL  = 'd100
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        mrst_n,
    input  logic        prst_n,
    input  logic [1:0]  bus_cfg,
    input  logic        ld_n,
    input  logic        wen_n,
    input  logic        ren_n,
    input  logic [35:0] din,
    input  logic [35:0] fifo_word,
    output logic [35:0] q,
    output logic        pae_ok,
    output logic        paf_ok
);

    localparam int PAD_R = 64 - OFS_W;

    logic             wr_stb;
    logic             rd_stb;
    logic             rd_step;
    logic             fifo_rd;
    seg_e             wseg;
    seg_e             rseg;
    logic [OFS_W-1:0] e_nxt;
    logic [OFS_W-1:0] f_nxt;
    logic             e_good;
    logic             f_good;
    logic [OFS_W-1:0] src;
    logic [63:0]      rext;
    logic [35:0]      rmask;
    logic [35:0]      rd_seg;
    int               rw;
    int               rlo;

    assign wr_stb  = !ld_n && !wen_n;
    assign rd_stb  = !ld_n && !ren_n;
    assign rd_step = rd_stb && prst_n;
    assign fifo_rd = ld_n && !ren_n;

    ofs_seq u_wseq (
        .clk   (wclk),
        .rst_n (mrst_n),
        .cfg   (bus_cfg),
        .step  (wr_stb),
        .seg   (wseg)
    );

    ofs_seq u_rseq (
        .clk   (rclk),
        .rst_n (mrst_n),
        .cfg   (bus_cfg),
        .step  (rd_step),
        .seg   (rseg)
    );

    ofs_store #(
        .OFS_W     (OFS_W),
        .DEF_EMPTY (DEF_EMPTY),
        .DEF_FULL  (DEF_FULL)
    ) u_store (
        .clk    (wclk),
        .rst_n  (mrst_n),
        .cfg    (bus_cfg),
        .wr     (wr_stb),
        .wseg   (wseg),
        .din    (din),
        .e_nxt  (e_nxt),
        .f_nxt  (f_nxt),
        .e_good (e_good),
        .f_good (f_good)
    );

    ofs_flag_sync u_esync (
        .clk   (rclk),
        .rst_n (mrst_n),
        .lvl   (e_good),
        .ok    (pae_ok)
    );

    ofs_flag_sync u_fsync (
        .clk   (wclk),
        .rst_n (mrst_n),
        .lvl   (f_good),
        .ok    (paf_ok)
    );

    // segment select, taking any same-edge write into account
    always_comb begin
        src    = is_full(rseg) ? f_nxt : e_nxt;
        rw     = seg_width(bus_cfg);
        rlo    = seg_index(rseg) * rw;
        rmask  = (36'd1 << rw) - 36'd1;
        rext   = {{PAD_R{1'b0}}, src} >> rlo;
        rd_seg = rext[35:0] & rmask;
    end

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            q <= '0;
        end else if (!prst_n) begin
            q <= '0;
        end else if (rd_stb) begin
            q <= rd_seg;
        end else if (fifo_rd) begin
            q <= fifo_word;
        end
    end

    // R9
    prst_keep_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        !prst_n |=> ((q == '0) && $stable(rseg)));

    // R8
    q_keep_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (prst_n && ren_n) |=> $stable(q));

    // R8
    fifo_pass_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (prst_n && ld_n && !ren_n) |=> (q == $past(fifo_word)));

endmodule

// File: tb/ofs_access_port_tb_top.sv
`timescale 1ns/1ps
module ofs_access_port_tb_top;

    localparam int          OFS_W = 20;
    localparam logic [19:0] DEF_E = 20'h00007;
    localparam logic [19:0] DEF_F = 20'h00064;

    logic        clk = 1'b0;
    logic        mrst_n, prst_n, ld_n, wen_n, ren_n;
    logic [1:0]  bus_cfg;
    logic [35:0] din, fifo_word, q;
    logic        pae_ok, paf_ok;

    always #2.5 clk = ~clk;

    ofs_access_port #(.OFS_W(OFS_W), .DEF_EMPTY(DEF_E), .DEF_FULL(DEF_F)) dut_i (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .bus_cfg(bus_cfg),
        .ld_n(ld_n), .wen_n(wen_n), .ren_n(ren_n), .din(din), .fifo_word(fifo_word),
        .q(q), .pae_ok(pae_ok), .paf_ok(paf_ok)
    );

    // behavioural reference
    int          m_wp, m_rp;
    logic [63:0] m_e, m_f;
    logic [35:0] m_q;
    logic        m_eg, m_fg, m_e1, m_e2, m_f1, m_f2;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    function automatic int nseg(input logic [1:0] c);
        if (c == 2'd1) return 2;
        if (c == 2'd2) return 3;
        return 1;
    endfunction

    function automatic int swid(input logic [1:0] c);
        if (c == 2'd1) return 18;
        if (c == 2'd2) return 9;
        return 36;
    endfunction

    task automatic model_reset();
        m_wp = 0; m_rp = 0;
        m_e = 64'(DEF_E); m_f = 64'(DEF_F);
        m_q = '0;
        m_eg = 1; m_fg = 1; m_e1 = 1; m_e2 = 1; m_f1 = 1; m_f2 = 1;
    endtask

    task automatic model_step();
        int S, W, k, pos;
        logic wr, rd, frd, n_e1, n_e2, n_f1, n_f2;
        logic [35:0] v;
        S = nseg(bus_cfg);
        W = swid(bus_cfg);
        wr  = !ld_n && !wen_n;
        rd  = !ld_n && !ren_n && prst_n;
        frd = ld_n && !ren_n;
        n_e1 = m_eg; n_e2 = m_e1; n_f1 = m_fg; n_f2 = m_f1;
        if (wr) begin
            k = m_wp % S;
            for (int b = 0; b < W; b++) begin
                pos = k * W + b;
                if (pos < OFS_W) begin
                    if (m_wp < S) m_e[pos[5:0]] = din[b[5:0]];
                    else          m_f[pos[5:0]] = din[b[5:0]];
                end
            end
            if (m_wp < S) begin
                if (m_wp == 0) m_fg = 0;
                m_eg = (k == S - 1);
            end else begin
                m_fg = (k == S - 1);
            end
            m_wp = (m_wp + 1) % (2 * S);
        end
        if (!prst_n) begin
            m_q = '0;
        end else if (rd) begin
            k = m_rp % S;
            v = '0;
            for (int b = 0; b < W; b++) begin
                pos = k * W + b;
                if (pos < OFS_W) v[b[5:0]] = (m_rp < S) ? m_e[pos[5:0]] : m_f[pos[5:0]];
            end
            m_q = v;
            m_rp = (m_rp + 1) % (2 * S);
        end else if (frd) begin
            m_q = fifo_word;
        end
        m_e1 = n_e1; m_e2 = n_e2; m_f1 = n_f1; m_f2 = n_f2;
    endtask

    always @(posedge clk) begin
        if (mrst_n) model_step();
    end

    task automatic chk(input string t, input string what, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(tag, "q", q, m_q);
            chk("R10 R11", "pae_ok", 36'(pae_ok), 36'(m_e2));
            chk("R10 R11", "paf_ok", 36'(paf_ok), 36'(m_f2));
        end
    end

    task automatic cyc(input logic l, input logic w, input logic r, input logic [35:0] d, input logic [35:0] fw);
        @(negedge clk);
        #0.5;
        ld_n = l; wen_n = w; ren_n = r; din = d; fifo_word = fw;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 1, 1, '0, '0);
    endtask

    task automatic mreset(input logic [1:0] c);
        @(negedge clk);
        #0.5;
        mrst_n = 0; bus_cfg = c; ld_n = 1; wen_n = 1; ren_n = 1; prst_n = 1;
        model_reset();
        repeat (3) @(negedge clk);
        #0.5;
        mrst_n = 1;
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        mrst_n = 0; prst_n = 1; ld_n = 1; wen_n = 1; ren_n = 1;
        din = '0; fifo_word = '0; bus_cfg = 2'd0;
        model_reset();
        repeat (3) @(negedge clk);
        #0.5;
        mrst_n = 1;

        // R1: read back the defaults
        tag = "R1";
        idle(1);
        cyc(0, 1, 0, '0, '0);
        cyc(0, 1, 0, '0, '0);
        idle(2);

        // R2: 36-bit alternation and wrap
        tag = "R2";
        cyc(0, 0, 1, 36'h0000_1234_5, '0);
        cyc(0, 0, 1, 36'h0000_ABCD_E, '0);
        cyc(0, 0, 1, 36'hF_FFFF_0042, '0);
        idle(3);
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, '0, '0);
        idle(1);

        // R7: pauses, stray FIFO writes
        tag = "R7";
        cyc(1, 0, 1, 36'h0_0000_0999, '0);
        cyc(0, 1, 1, 36'h0_0000_0888, '0);
        idle(1);
        cyc(0, 1, 0, '0, '0);
        cyc(0, 0, 1, 36'h0_0000_0555, '0);
        idle(2);
        cyc(0, 1, 0, '0, '0);
        idle(1);

        // R8: ordinary read then hold
        tag = "R8";
        cyc(1, 1, 0, '0, 36'h9_8765_4321);
        idle(2);

        // R6: offset read overwrites the FIFO word
        tag = "R6";
        cyc(0, 1, 0, '0, 36'h1_1111_1111);
        idle(1);

        // R9: partial reset clears q, keeps the pointer
        tag = "R9";
        prst_n = 0;
        cyc(0, 1, 0, '0, '0);
        idle(1);
        prst_n = 1;
        cyc(0, 1, 0, '0, '0);
        idle(1);

        // R12: same-edge write and read
        tag = "R12";
        cyc(0, 0, 0, 36'h0_000C_AFE1, '0);
        cyc(0, 0, 0, 36'h0_0003_1337, '0);
        idle(3);

        // R3: 18-bit order, interleaved with FIFO traffic
        mreset(2'd1);
        tag = "R3";
        cyc(0, 0, 1, 36'h0_0002_ABCD, '0);
        cyc(1, 0, 1, 36'h0_0000_0777, '0);
        cyc(0, 0, 1, 36'h0_0001_0003, '0);
        idle(3);
        cyc(0, 0, 1, 36'h0_0003_1111, '0);
        cyc(0, 0, 1, 36'h0_0000_0002, '0);
        idle(3);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, '0, '0);
        idle(1);

        // R4: 9-bit order, upper bits dropped
        mreset(2'd2);
        tag = "R4";
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 36'hF_FFFF_FE00 | 36'(i * 37 + 5), '0);
        idle(3);
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, '0, '0);
        idle(2);

        // R5: one segment replaced, the rest kept
        mreset(2'd1);
        tag = "R5";
        cyc(0, 0, 1, 36'hF_FFFF_FFFF, '0);
        idle(3);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0, '0);
        idle(2);

        // mixed traffic in every strap setting
        for (int c = 0; c < 4; c++) begin
            mreset(2'(c));
            tag = "R2 R3 R4 R6 R7 R8 R9 R12";
            for (int i = 0; i < 400; i++) begin
                prst_n = (($urandom % 20) != 0);
                cyc(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                    {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)});
            end
            prst_n = 1;
            idle(3);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule